// File: doc/BRIEF.md
# Chained Debug Trigger Resolver

This block keeps the settings of ten hardware debug triggers and turns the raw per-trigger match flags into a trap decision for each instruction. The triggers are grouped in five fixed pairs. Group i holds triggers 2i and 2i+1. The kinds of source per group are fetch+fetch, store+store, load+load, fetch+store and fetch+load. Each pair can be chained. A chained pair fires only when both of its triggers match the same instruction and both use the same timing.

Each trigger's timing bit picks when its trap is taken. A value of 0 traps at the matching instruction. A value of 1 traps at the next valid instruction, and a pending register holds that deferred trap until then. A pipeline flush drops the pending trap. The stored settings are also driven out as a flat vector, so the external address and data comparators can use them.

Top module: `trig_resolver`

## Requirements
- R1: After reset, every trigger's enable bit, every group chain bit, the pending deferred trap and both trap outputs are zero.
- R2: A write with `cfg_mem_side`=0 uses `cfg_idx[1:0]` values 0..3 to select triggers 0, 1, 6 and 8. A write with `cfg_mem_side`=1 uses `cfg_idx` values 0..5 to select triggers 2, 3, 4, 5, 7 and 9. Memory-side index values 6 and 7 change nothing. Trigger t occupies `cfg_flat[t*(CMP_W+6) +: CMP_W+6]`, with the compare value in bits CMP_W-1:0. Above it, at offsets CMP_W up to CMP_W+5, sit action, timing, select, match type (2 bits) and enable.
- R3: The chain bit of group g, shown on `grp_chain[g]`, is loaded only by a write to trigger 2g. The chain field of a write to trigger 2g+1 is ignored.
- R4: Group 1 (the two store triggers) can never be chained. A write that asks for it leaves `grp_chain[1]` at 0, and those triggers keep acting alone.
- R5: In an unchained group, a trigger fires when its enable bit is 1 and its hit input is 1. A disabled trigger's hit has no effect.
- R6: In a chained group, neither trigger fires unless both are enabled and both hit on the same instruction.
- R7: In a chained group whose two triggers have different timing bits, neither trigger fires, even when both hit.
- R8: A fired trigger with timing 0 raises `trap_now` in the same cycle. A fired trigger with timing 1 raises `trap_next` and arms a pending trap. That pending trap raises `trap_now` on the next cycle with `instr_valid`=1, and it is kept across cycles without a valid instruction.
- R9: If a timing-0 trigger fires or a pending trap is being raised, `trap_next` stays 0 and no new pending trap is armed.
- R10: `flush`=1 forces both trap outputs to 0 in that cycle and clears the pending trap.
- R11: With `instr_valid`=0, both trap outputs are 0 whatever the hit inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mem_side | input | 1 | 0: fetch-side index, 1: memory-side index |
| cfg_idx | input | 3 | Trigger index within the selected side |
| cfg_enable | input | 1 | Enable bit to store |
| cfg_mtype | input | 2 | Match type to store |
| cfg_sel | input | 1 | Select bit to store |
| cfg_timing | input | 1 | Timing bit to store (0 now, 1 next) |
| cfg_action | input | 1 | Action bit to store |
| cfg_chain | input | 1 | Chain request (used on even triggers only) |
| cfg_cmp | input | CMP_W | Compare value to store |
| instr_valid | input | 1 | Current instruction is valid |
| flush | input | 1 | Pipeline flush |
| hit | input | 10 | Raw comparator match per trigger |
| trap_now | output | 1 | Trap at the current instruction |
| trap_next | output | 1 | Trap at the following instruction |
| grp_chain | output | 5 | Stored chain bit per group |
| cfg_flat | output | 10*(CMP_W+6) | Stored settings of all triggers |

## Verification
The bench builds the block with CMP_W=16. This keeps the flat settings vector short enough that the bench can compare it whole after every write. It can then see that a write changed only the intended slot, and that ignored writes changed nothing. The number of groups and their source kinds are fixed, so every group can be reached. This includes the store pair whose chaining is refused and the mixed fetch/load pair used for chaining and timing-mismatch cases. Deferred traps are checked across idle cycles, flushes and collisions with timing-0 hits.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int NUM_GRP   = 5;
    localparam int NUM_TRIG  = 2 * NUM_GRP;
    localparam int TIDX_W    = $clog2(NUM_TRIG);
    localparam int STORE_GRP = 1;

    // Per-trigger control fields; action sits at the least significant bit
    typedef struct packed {
        logic       en;
        logic [1:0] mtype;
        logic       sel;
        logic       timing;
        logic       action;
    } trig_ctl_t;

    localparam int CTL_W = $bits(trig_ctl_t);

    typedef struct packed {
        logic              ok;
        logic [TIDX_W-1:0] num;
    } slot_t;

    // Fetch-side index -> trigger number
    function automatic slot_t fetch_slot(input logic [1:0] idx);
        slot_t s;
        s.ok = 1'b1;
        case (idx)
            2'd0:    s.num = TIDX_W'(0);
            2'd1:    s.num = TIDX_W'(1);
            2'd2:    s.num = TIDX_W'(6);
            default: s.num = TIDX_W'(8);
        endcase
        return s;
    endfunction

    // Memory-side index -> trigger number; indices 6 and 7 select nothing
    function automatic slot_t mem_slot(input logic [2:0] idx);
        slot_t s;
        s.ok = 1'b1;
        case (idx)
            3'd0:    s.num = TIDX_W'(2);
            3'd1:    s.num = TIDX_W'(3);
            3'd2:    s.num = TIDX_W'(4);
            3'd3:    s.num = TIDX_W'(5);
            3'd4:    s.num = TIDX_W'(7);
            3'd5:    s.num = TIDX_W'(9);
            default: begin
                s.ok  = 1'b0;
                s.num = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
    import trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic                       mem_side,
    input  logic [2:0]                 idx,
    input  trig_ctl_t                  ctl_in,
    input  logic                       chain_in,
    input  logic [CMP_W-1:0]           cmp_in,
    output trig_ctl_t [NUM_TRIG-1:0]   ctl_o,
    output logic [NUM_TRIG*CMP_W-1:0]  cmp_o,
    output logic [NUM_GRP-1:0]         chain_o
);

    slot_t tgt;

    always_comb begin
        tgt = mem_side ? mem_slot(idx) : fetch_slot(idx[1:0]);
    end

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        logic wr_t;
        assign wr_t = we && tgt.ok && (tgt.num == TIDX_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_o[t]                 <= '0;
                cmp_o[t*CMP_W +: CMP_W]  <= '0;
            end else if (wr_t) begin
                ctl_o[t]                 <= ctl_in;
                cmp_o[t*CMP_W +: CMP_W]  <= cmp_in;
            end
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chain
        localparam bit MAY_CHAIN = (g != STORE_GRP);
        logic wr_lead;
        assign wr_lead = we && tgt.ok && (tgt.num == TIDX_W'(2 * g));

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_o[g] <= 1'b0;
            end else if (wr_lead) begin
                chain_o[g] <= MAY_CHAIN ? chain_in : 1'b0;
            end
        end
    end

endmodule

// File: rtl/trig_pair_resolve.sv
module trig_pair_resolve (
    input  logic [1:0] eff,
    input  logic [1:0] tim,
    input  logic       chain,
    output logic [1:0] fire
);

    logic both_ok;

    always_comb begin
        both_ok = eff[0] && eff[1] && (tim[0] == tim[1]);
        fire    = chain ? {2{both_ok}} : eff;
    end

endmodule

// File: rtl/trig_defer.sv
module trig_defer (
    input  logic clk,
    input  logic rst,
    input  logic instr_valid,
    input  logic flush,
    input  logic now_any,
    input  logic next_any,
    output logic trap_now,
    output logic trap_next
);

    logic pend_q;
    logic live;

    always_comb begin
        live      = instr_valid && !flush;
        trap_now  = live && (now_any || pend_q);
        trap_next = live && next_any && !trap_now;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= 1'b0;
        end else if (instr_valid) begin
            pend_q <= trap_next;
        end
    end

endmodule

// File: rtl/trig_resolver.sv
module trig_resolver
    import trig_pkg::*;
#(
    parameter int CMP_W = 64,
    localparam int SLOT_W = CTL_W + CMP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic                         cfg_mem_side,
    input  logic [2:0]                   cfg_idx,
    input  logic                         cfg_enable,
    input  logic [1:0]                   cfg_mtype,
    input  logic                         cfg_sel,
    input  logic                         cfg_timing,
    input  logic                         cfg_action,
    input  logic                         cfg_chain,
    input  logic [CMP_W-1:0]             cfg_cmp,
    input  logic                         instr_valid,
    input  logic                         flush,
    input  logic [NUM_TRIG-1:0]          hit,
    output logic                         trap_now,
    output logic                         trap_next,
    output logic [NUM_GRP-1:0]           grp_chain,
    output logic [NUM_TRIG*SLOT_W-1:0]   cfg_flat
);

    trig_ctl_t                 ctl_in;
    trig_ctl_t [NUM_TRIG-1:0]  ctl;
    logic [NUM_TRIG*CMP_W-1:0] cmp;
    logic [NUM_TRIG-1:0]       eff;
    logic [NUM_TRIG-1:0]       tim;
    logic [NUM_TRIG-1:0]       fire;
    logic                      now_any;
    logic                      next_any;

    always_comb begin
        ctl_in.en     = cfg_enable;
        ctl_in.mtype  = cfg_mtype;
        ctl_in.sel    = cfg_sel;
        ctl_in.timing = cfg_timing;
        ctl_in.action = cfg_action;
    end

    trig_cfg_store #(.CMP_W(CMP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .mem_side (cfg_mem_side),
        .idx      (cfg_idx),
        .ctl_in   (ctl_in),
        .chain_in (cfg_chain),
        .cmp_in   (cfg_cmp),
        .ctl_o    (ctl),
        .cmp_o    (cmp),
        .chain_o  (grp_chain)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
        assign eff[t] = ctl[t].en && hit[t];
        assign tim[t] = ctl[t].timing;
        assign cfg_flat[t*SLOT_W +: SLOT_W] = {ctl[t], cmp[t*CMP_W +: CMP_W]};
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        trig_pair_resolve u_pair (
            .eff   (eff[2*g +: 2]),
            .tim   (tim[2*g +: 2]),
            .chain (grp_chain[g]),
            .fire  (fire[2*g +: 2])
        );
    end

    always_comb begin
        now_any  = |(fire & ~tim);
        next_any = |(fire & tim);
    end

    trig_defer u_defer (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .flush       (flush),
        .now_any     (now_any),
        .next_any    (next_any),
        .trap_now    (trap_now),
        .trap_next   (trap_next)
    );

endmodule

// File: rtl/trig_resolver_chk.sv
module trig_resolver_chk
    import trig_pkg::*;
#(
    parameter int CMP_W = 64,
    localparam int SLOT_W = CTL_W + CMP_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       instr_valid,
    input logic                       flush,
    input logic                       trap_now,
    input logic                       trap_next,
    input logic [NUM_GRP-1:0]         grp_chain,
    input logic [NUM_TRIG*SLOT_W-1:0] cfg_flat
);

    logic [NUM_TRIG-1:0] en_vec;

    always_comb begin
        for (int t = 0; t < NUM_TRIG; t++) begin
            en_vec[t] = cfg_flat[t*SLOT_W + CMP_W + 5];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (grp_chain == '0) && (en_vec == '0)); // R1

    AST_STORE_NOCHAIN: assert property (@(posedge clk) disable iff (rst)
        !grp_chain[STORE_GRP]); // R4

    AST_DEFER_RAISE: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !flush && trap_next) |=> (!instr_valid || flush || trap_now)); // R8

    AST_NOW_EXCL_NEXT: assert property (@(posedge clk) disable iff (rst)
        !(trap_now && trap_next)); // R9

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> !trap_now && !trap_next); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !trap_now && !trap_next); // R11

endmodule

bind trig_resolver trig_resolver_chk #(.CMP_W(CMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .flush       (flush),
    .trap_now    (trap_now),
    .trap_next   (trap_next),
    .grp_chain   (grp_chain),
    .cfg_flat    (cfg_flat)
);

// File: tb/trig_resolver_tb.sv
`timescale 1ns/1ps
module trig_resolver_tb;

    localparam int CW  = 16;
    localparam int SW  = CW + 6;
    localparam int NT  = 10;
    localparam int NG  = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic            cfg_mem_side = 1'b0;
    logic [2:0]      cfg_idx = '0;
    logic            cfg_enable = 1'b0;
    logic [1:0]      cfg_mtype = '0;
    logic            cfg_sel = 1'b0;
    logic            cfg_timing = 1'b0;
    logic            cfg_action = 1'b0;
    logic            cfg_chain = 1'b0;
    logic [CW-1:0]   cfg_cmp = '0;
    logic            instr_valid = 1'b0;
    logic            flush = 1'b0;
    logic [NT-1:0]   hit = '0;
    logic            trap_now;
    logic            trap_next;
    logic [NG-1:0]   grp_chain;
    logic [NT*SW-1:0] cfg_flat;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trig_resolver #(.CMP_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mem_side(cfg_mem_side),
        .cfg_idx(cfg_idx), .cfg_enable(cfg_enable), .cfg_mtype(cfg_mtype),
        .cfg_sel(cfg_sel), .cfg_timing(cfg_timing), .cfg_action(cfg_action),
        .cfg_chain(cfg_chain), .cfg_cmp(cfg_cmp), .instr_valid(instr_valid),
        .flush(flush), .hit(hit), .trap_now(trap_now), .trap_next(trap_next),
        .grp_chain(grp_chain), .cfg_flat(cfg_flat)
    );

    // Bench model of the stored settings, built from the requirements
    logic          m_en  [NT];
    logic [1:0]    m_ty  [NT];
    logic          m_sel [NT];
    logic          m_tim [NT];
    logic          m_act [NT];
    logic [CW-1:0] m_cmp [NT];
    logic          m_chain [NG];
    logic          m_pend;

    typedef struct {
        logic  now;
        logic  nxt;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NT*SW-1:0] model_flat();
        logic [NT*SW-1:0] f;
        for (int t = 0; t < NT; t++)
            f[t*SW +: SW] = {m_en[t], m_ty[t], m_sel[t], m_tim[t], m_act[t], m_cmp[t]};
        return f;
    endfunction

    function automatic logic [NG-1:0] model_chain();
        logic [NG-1:0] c;
        for (int g = 0; g < NG; g++) c[g] = m_chain[g];
        return c;
    endfunction

    // R2 index map, from the requirement text
    function automatic int target_of(input logic side, input logic [2:0] idx);
        if (!side) begin
            case (idx[1:0])
                2'd0: return 0;
                2'd1: return 1;
                2'd2: return 6;
                default: return 8;
            endcase
        end
        case (idx)
            3'd0: return 2;
            3'd1: return 3;
            3'd2: return 4;
            3'd3: return 5;
            3'd4: return 7;
            3'd5: return 9;
            default: return -1;
        endcase
    endfunction

    task automatic cfg_wr(input logic side, input logic [2:0] idx, input logic en,
                          input logic [1:0] ty, input logic sel, input logic tim,
                          input logic act, input logic chain, input logic [CW-1:0] cmp,
                          input string tag);
        int t;
        @(negedge clk);
        instr_valid = 1'b0; flush = 1'b0; hit = '0;
        cfg_we = 1'b1; cfg_mem_side = side; cfg_idx = idx; cfg_enable = en;
        cfg_mtype = ty; cfg_sel = sel; cfg_timing = tim; cfg_action = act;
        cfg_chain = chain; cfg_cmp = cmp;
        t = target_of(side, idx);
        if (t >= 0) begin
            m_en[t] = en; m_ty[t] = ty; m_sel[t] = sel; m_tim[t] = tim;
            m_act[t] = act; m_cmp[t] = cmp;
            if (t % 2 == 0) m_chain[t/2] = (t/2 == 1) ? 1'b0 : chain;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(cfg_flat == model_flat(), tag, "cfg_flat", 64'(cfg_flat ^ model_flat()), 64'h0);
        check(grp_chain == model_chain(), tag, "grp_chain", 64'(grp_chain), 64'(model_chain()));
    endtask

    // Driver: one instruction cycle, expected verdict pushed to the scoreboard
    task automatic step(input logic v, input logic fl, input logic [NT-1:0] h, input string tag);
        logic now_any, next_any, fa, fb, ea, eb;
        exp_t e;
        @(negedge clk);
        instr_valid = v; flush = fl; hit = h;
        now_any = 1'b0; next_any = 1'b0;
        for (int g = 0; g < NG; g++) begin
            ea = m_en[2*g] & h[2*g];
            eb = m_en[2*g+1] & h[2*g+1];
            if (m_chain[g]) begin
                fa = ea & eb & (m_tim[2*g] == m_tim[2*g+1]);
                fb = fa;
            end else begin
                fa = ea; fb = eb;
            end
            if (fa) begin if (m_tim[2*g]) next_any = 1'b1; else now_any = 1'b1; end
            if (fb) begin if (m_tim[2*g+1]) next_any = 1'b1; else now_any = 1'b1; end
        end
        e.now = v & !fl & (now_any | m_pend);
        e.nxt = v & !fl & next_any & !e.now;
        e.tag = tag;
        if (fl) m_pend = 1'b0;
        else if (v) m_pend = e.nxt;
        sb_q.push_back(e);
    endtask

    // Monitor: compares outputs a quarter period before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({trap_now, trap_next} == {e.now, e.nxt}, e.tag, "trap_now,trap_next",
                      64'({trap_now, trap_next}), 64'({e.now, e.nxt}));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_en[t] = 0; m_ty[t] = 0; m_sel[t] = 0; m_tim[t] = 0; m_act[t] = 0; m_cmp[t] = 0;
        end
        for (int g = 0; g < NG; g++) m_chain[g] = 0;
        m_pend = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(cfg_flat == '0, "R1", "cfg_flat", 64'(cfg_flat), 64'h0);
        check(grp_chain == '0, "R1", "grp_chain", 64'(grp_chain), 64'h0);
        check({trap_now, trap_next} == 2'b00, "R1", "traps", 64'({trap_now, trap_next}), 64'h0);
        step(1, 0, '1, "R1_R5 disabled hits ignored");

        // R2 mapping and field layout
        cfg_wr(0, 3'd0, 1, 2'd2, 1, 0, 1, 0, 16'hA5C3, "R2 fetch idx0");
        cfg_wr(0, 3'd2, 0, 2'd1, 0, 1, 0, 0, 16'h1234, "R2 fetch idx2");
        cfg_wr(1, 3'd1, 1, 2'd3, 0, 1, 1, 0, 16'hBEEF, "R2 mem idx1");
        cfg_wr(1, 3'd6, 1, 2'd3, 1, 1, 1, 1, 16'hFFFF, "R2 mem idx6 ignored");
        cfg_wr(1, 3'd7, 1, 2'd1, 1, 0, 1, 1, 16'h0F0F, "R2 mem idx7 ignored");

        // R5 / R8 single triggers
        step(1, 0, 10'b00_0000_0001, "R5_R8 timing0 now");
        step(1, 0, 10'b00_0100_0000, "R5 disabled trigger 6 ignored");
        step(1, 0, 10'b00_0000_1000, "R8 timing1 next");
        step(0, 0, '0, "R11 idle keeps pending");
        step(0, 0, 10'b00_0000_1001, "R11 hits without valid");
        step(1, 0, '0, "R8 pending raised");
        step(1, 0, '0, "R8 pending consumed");

        // R10 flush
        step(1, 0, 10'b00_0000_1000, "R10 arm");
        step(0, 1, '0, "R10 flush");
        step(1, 0, '0, "R10 pending gone");
        step(1, 1, 10'b00_0000_0001, "R10 flush with hit");

        // R9 priority
        step(1, 0, 10'b00_0000_1001, "R9 now over next");
        step(1, 0, '0, "R9 no pending armed");
        step(1, 0, 10'b00_0000_1000, "R9 arm");
        step(1, 0, 10'b00_0000_1000, "R9 pending over new next");
        step(1, 0, '0, "R9 nothing left");

        // R3 / R6 chaining group 4 (triggers 8, 9)
        cfg_wr(0, 3'd3, 1, 2'd0, 0, 0, 0, 1, 16'h0008, "R3 lead write sets chain");
        cfg_wr(1, 3'd5, 1, 2'd0, 0, 0, 0, 0, 16'h0009, "R3 odd write ignores chain");
        step(1, 0, 10'b01_0000_0000, "R6 lone hit 8");
        step(1, 0, 10'b10_0000_0000, "R6 lone hit 9");
        step(1, 0, 10'b11_0000_0000, "R6 pair hit");

        // R7 timing mismatch
        cfg_wr(1, 3'd5, 1, 2'd0, 0, 1, 0, 1, 16'h0009, "R7 trigger 9 timing1");
        step(1, 0, 10'b11_0000_0000, "R7 mismatch suppressed");
        cfg_wr(0, 3'd3, 1, 2'd0, 0, 1, 0, 1, 16'h0008, "R8 trigger 8 timing1");
        step(1, 0, 10'b11_0000_0000, "R8 chained next");
        step(1, 0, '0, "R8 chained pending raised");

        // R4 store group chaining refused
        cfg_wr(1, 3'd0, 1, 2'd1, 0, 0, 0, 1, 16'h0002, "R4 chain request refused");
        cfg_wr(1, 3'd1, 1, 2'd3, 0, 0, 1, 0, 16'hBEEF, "R4 trigger 3 timing0");
        step(1, 0, 10'b00_0000_0100, "R4 trigger 2 fires alone");

        // R3 unchain via lead trigger
        cfg_wr(0, 3'd3, 1, 2'd0, 0, 0, 0, 0, 16'h0008, "R3 chain cleared");
        step(1, 0, 10'b01_0000_0000, "R3_R5 unchained lone hit 8");
        step(1, 0, '0, "R5 quiet");

        @(negedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule